// File: doc/BRIEF.md
# Frequency-Locked Tuning Controller

This block regulates a tuner's frequency by counting, not by comparing phase. A time-reference counter runs from the reference clock. In each regulation cycle it opens a gate window. During the window the block counts rising edges of the prescaled tuner signal. It then subtracts that count from a programmed target word, so one count step equals one 50 kHz frequency step. The result drives an external charge pump through three signals: a direction, a 3-bit magnitude code for the pump DAC, and an enable pulse of fixed length.

Two cycle timings are supported, one for each prescaler setting:

| Setting | Cycle | Gate | Reference clocks (cycle / gate) |
|---|---|---|---|
| ÷256 | 6.4 ms | 5.12 ms | 25600 / 20480 |
| ÷64 | 2.56 ms | 1.28 ms | 10240 / 5120 |

These figures assume the 4 MHz reference. The tolerance window is programmable. Inside it, the block reports lock and normally leaves the pump idle. With AFC enabled, the pump keeps correcting even inside the window.

Top module: `fll_tune_ctrl`

## Requirements
- R1: While reset is asserted, and until the first compare, `pump_up`, `pump_dn`, `pump_mag` and `in_window` are all 0.
- R2: The cycle lasts CYC_LONG reference clocks when `mode_short`=0 and CYC_SHORT when it is 1. Cycle position 0 is the start of a cycle.
- R3: Only rising edges of `fin_pre` that fall inside the gate are counted. The gate covers positions 1 to the gate length, and each edge is seen two clocks after it is sampled. The count is cleared at position 0, so edges after the gate do not affect the next result.
- R4: The error is target − count. A positive error pulses `pump_up` and a negative error pulses `pump_dn`. The two are never high together.
- R5: `pump_mag` equals |error| saturated at 2^DAC_W−1. It is nonzero whenever a pump pulse starts.
- R6: A pump pulse lasts exactly PUMP_CLKS reference clocks. It starts at cycle position gate length + 2.
- R7: `in_window` is 1 when |error| ≤ `tune_window`. It changes only at the compare point (position gate length + 1) and holds for the rest of the cycle.
- R8: If the error is inside the window and `afc_en`=0, no pump pulse is produced. If `afc_en`=1, any nonzero error is pumped. `tune_window` and `afc_en` are sampled at the compare point.
- R9: `target_word` and `mode_short` are captured only at cycle position 0. A change in mid-cycle first affects the following cycle.
- R10: The count saturates at 2^CNT_W−1 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (4 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin_pre | input | 1 | Prescaled tuner frequency, asynchronous |
| target_word | input | CNT_W | Target frequency in 50 kHz steps |
| mode_short | input | 1 | 0: ÷256 timing, 1: ÷64 timing |
| tune_window | input | WIN_W | Lock tolerance in count steps |
| afc_en | input | 1 | Keep pumping inside the window |
| pump_up | output | 1 | Charge-pump source enable |
| pump_dn | output | 1 | Charge-pump sink enable |
| pump_mag | output | DAC_W | Pump DAC magnitude code |
| in_window | output | 1 | Error within tolerance |

## Verification
Each result has a fixed latency:

- A `fin_pre` edge sampled at one clock reaches the count two clocks later.
- Direction, magnitude and window status change one clock after the compare point, so they are first visible at position gate length + 2.
- The pump pulse then stays high for PUMP_CLKS clocks.
- A new target or mode takes effect only from the next position 0.

The bench keeps a behavioural model of cycle position, count and pump timer that advances on every rising edge. It compares all four outputs at every falling edge. Directed checks measure the distance between pump rises to confirm the cycle lengths, including the mixed 140-clock interval seen across a mode change.

// File: rtl/fll_pkg.sv
package fll_pkg;

   typedef enum logic {
      MODE_LONG  = 1'b0,
      MODE_SHORT = 1'b1
   } fll_mode_e;

   function automatic int fll_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fll_edge_sync.sv
module fll_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   // chain[0..STAGES-1] resynchronise; chain[STAGES] holds the prior value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], din};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fll_timebase.sv
module fll_timebase
   import fll_pkg::*;
#(
   parameter int CNT_W      = 15,
   parameter int GATE_LONG  = 20480,
   parameter int CYC_LONG   = 25600,
   parameter int GATE_SHORT = 5120,
   parameter int CYC_SHORT  = 10240,
   parameter int TB_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic [CNT_W-1:0] target_i,
   output logic [CNT_W-1:0] target_q,
   output logic             cnt_clr,
   output logic             gate_open,
   output logic             cmp_stb
);
   localparam logic [TB_W-1:0] GL_C = TB_W'(GATE_LONG);
   localparam logic [TB_W-1:0] GS_C = TB_W'(GATE_SHORT);
   localparam logic [TB_W-1:0] CL_LAST = TB_W'(CYC_LONG - 1);
   localparam logic [TB_W-1:0] CS_LAST = TB_W'(CYC_SHORT - 1);

   logic [TB_W-1:0] tb_cnt;
   logic [TB_W-1:0] gate_end;
   logic [TB_W-1:0] cyc_last;
   fll_mode_e       mode_q;

   always_comb begin
      if (mode_q == MODE_SHORT) begin
         gate_end = GS_C;
         cyc_last = CS_LAST;
      end else begin
         gate_end = GL_C;
         cyc_last = CL_LAST;
      end
   end

   // shadow registers follow the inputs only at position 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_cnt   <= '0;
         mode_q   <= MODE_LONG;
         target_q <= '0;
      end else begin
         if (tb_cnt == '0) begin
            mode_q   <= mode_i ? MODE_SHORT : MODE_LONG;
            target_q <= target_i;
         end
         tb_cnt <= (tb_cnt == cyc_last) ? '0 : tb_cnt + 1'b1;
      end
   end

   assign cnt_clr   = (tb_cnt == '0);
   assign gate_open = (tb_cnt != '0) && (tb_cnt <= gate_end);
   assign cmp_stb   = (tb_cnt == gate_end + TB_W'(1));
endmodule

// File: rtl/fll_freq_counter.sv
module fll_freq_counter #(
   parameter int CNT_W    = 15,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             gate,
   input  logic             pulse,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_inc;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (&count) ? count : count + 1'b1;
      end else begin : g_wrap
         assign cnt_inc = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count <= '0;
      else if (clr)            count <= '0;
      else if (gate && pulse)  count <= cnt_inc;
   end
endmodule

// File: rtl/fll_pump_ctrl.sv
module fll_pump_ctrl
   import fll_pkg::*;
#(
   parameter int CNT_W     = 15,
   parameter int WIN_W     = 4,
   parameter int DAC_W     = 3,
   parameter int PUMP_CLKS = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_stb,
   input  logic [CNT_W-1:0] target,
   input  logic [CNT_W-1:0] count,
   input  logic [WIN_W-1:0] window,
   input  logic             afc_en,
   output logic             pump_up,
   output logic             pump_dn,
   output logic [DAC_W-1:0] pump_mag,
   output logic             in_window
);
   localparam int ERR_W   = CNT_W + 1;
   localparam int CMP_W   = fll_max(CNT_W, WIN_W);
   localparam int PW      = $clog2(PUMP_CLKS + 1);
   localparam int MAG_MAX = (1 << DAC_W) - 1;

   logic signed [ERR_W-1:0] err;
   logic [CNT_W-1:0]        abs_err;
   logic                    win_now;
   logic                    fire;
   logic [DAC_W-1:0]        mag_now;
   logic [PW-1:0]           left;
   logic                    dir_up_q;

   assign err     = $signed({1'b0, target}) - $signed({1'b0, count});
   assign abs_err = err[ERR_W-1] ? CNT_W'(-err) : CNT_W'(err);
   assign win_now = CMP_W'(abs_err) <= CMP_W'(window);
   assign mag_now = (abs_err > CNT_W'(MAG_MAX)) ? DAC_W'(MAG_MAX) : abs_err[DAC_W-1:0];
   assign fire    = (abs_err != '0) && (!win_now || afc_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left      <= '0;
         dir_up_q  <= 1'b0;
         pump_mag  <= '0;
         in_window <= 1'b0;
      end else if (cmp_stb) begin
         in_window <= win_now;
         pump_mag  <= mag_now;
         dir_up_q  <= !err[ERR_W-1];
         left      <= fire ? PW'(PUMP_CLKS) : '0;
      end else if (left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign pump_up = (left != '0) &&  dir_up_q;
   assign pump_dn = (left != '0) && !dir_up_q;
endmodule

// File: rtl/fll_tune_ctrl.sv
module fll_tune_ctrl
   import fll_pkg::*;
#(
   parameter int CNT_W       = 15,
   parameter int WIN_W       = 4,
   parameter int DAC_W       = 3,
   parameter int GATE_LONG   = 20480,
   parameter int CYC_LONG    = 25600,
   parameter int GATE_SHORT  = 5120,
   parameter int CYC_SHORT   = 10240,
   parameter int PUMP_CLKS   = 256,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             fin_pre,
   input  logic [CNT_W-1:0] target_word,
   input  logic             mode_short,
   input  logic [WIN_W-1:0] tune_window,
   input  logic             afc_en,
   output logic             pump_up,
   output logic             pump_dn,
   output logic [DAC_W-1:0] pump_mag,
   output logic             in_window
);
   localparam int TB_W = $clog2(fll_max(CYC_LONG, CYC_SHORT) + 1);

   generate
      if (DAC_W >= CNT_W) begin : g_bad_dac
         $error("DAC_W must be narrower than CNT_W");
      end
      if (GATE_LONG + PUMP_CLKS + 2 > CYC_LONG) begin : g_bad_long
         $error("long cycle too short for gate plus pump pulse");
      end
      if (GATE_SHORT + PUMP_CLKS + 2 > CYC_SHORT) begin : g_bad_short
         $error("short cycle too short for gate plus pump pulse");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             fin_rise;
   logic             cnt_clr;
   logic             gate_open;
   logic             cmp_stb;
   logic [CNT_W-1:0] target_q;
   logic [CNT_W-1:0] meas_cnt;

   fll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .din  (fin_pre),
      .rise (fin_rise)
   );

   fll_timebase #(
      .CNT_W(CNT_W), .GATE_LONG(GATE_LONG), .CYC_LONG(CYC_LONG),
      .GATE_SHORT(GATE_SHORT), .CYC_SHORT(CYC_SHORT), .TB_W(TB_W)
   ) u_tb (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .mode_i   (mode_short),
      .target_i (target_word),
      .target_q (target_q),
      .cnt_clr  (cnt_clr),
      .gate_open(gate_open),
      .cmp_stb  (cmp_stb)
   );

   fll_freq_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk  (clk_ref),
      .rst_n(rst_n),
      .clr  (cnt_clr),
      .gate (gate_open),
      .pulse(fin_rise),
      .count(meas_cnt)
   );

   fll_pump_ctrl #(
      .CNT_W(CNT_W), .WIN_W(WIN_W), .DAC_W(DAC_W), .PUMP_CLKS(PUMP_CLKS)
   ) u_pump (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .cmp_stb  (cmp_stb),
      .target   (target_q),
      .count    (meas_cnt),
      .window   (tune_window),
      .afc_en   (afc_en),
      .pump_up  (pump_up),
      .pump_dn  (pump_dn),
      .pump_mag (pump_mag),
      .in_window(in_window)
   );
endmodule

// File: rtl/fll_tune_ctrl_chk.sv
module fll_tune_ctrl_chk #(
   parameter int CNT_W    = 15,
   parameter int DAC_W    = 3,
   parameter bit SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pump_up,
   input logic             pump_dn,
   input logic [DAC_W-1:0] pump_mag,
   input logic             in_window,
   input logic             cmp_stb,
   input logic             gate_open,
   input logic             cnt_clr,
   input logic [CNT_W-1:0] count
);
   // R4
   no_dual_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pump_up && pump_dn));

   // R5
   pump_mag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pump_up || pump_dn) |-> (pump_mag != '0));

   // R7
   window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_stb |=> $stable(in_window));

   // R3
   count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_open && !cnt_clr) |=> $stable(count));

   // R10
   count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SATURATE && gate_open && (&count)) |=> (&count));
endmodule

bind fll_tune_ctrl fll_tune_ctrl_chk #(
   .CNT_W(CNT_W), .DAC_W(DAC_W), .SATURATE(SATURATE)
) u_chk (
   .clk      (clk_ref),
   .rst_n    (rst_n),
   .pump_up  (pump_up),
   .pump_dn  (pump_dn),
   .pump_mag (pump_mag),
   .in_window(in_window),
   .cmp_stb  (cmp_stb),
   .gate_open(gate_open),
   .cnt_clr  (cnt_clr),
   .count    (meas_cnt)
);

// File: tb/fll_tune_ctrl_test.sv
module fll_tune_ctrl_test;
   localparam int CW = 6, WW = 3, DW = 3;
   localparam int GL = 200, CL = 260, GS = 80, CS = 130, PC = 20;
   localparam int CMAX = (1 << CW) - 1;
   localparam int MMAX = (1 << DW) - 1;

   logic clk = 1'b0, rst_n = 1'b0, fin = 1'b0, mode_short = 1'b0, afc_en = 1'b0;
   logic [CW-1:0] target_word = '0;
   logic [WW-1:0] tune_window = '0;
   logic          pump_up, pump_dn, in_window;
   logic [DW-1:0] pump_mag;

   int     errors = 0, checks = 0;
   bit     done = 0, run_cmp = 0;
   int     fin_half = 0, ph = 0;
   longint clk_no = 0;

   fll_tune_ctrl #(
      .CNT_W(CW), .WIN_W(WW), .DAC_W(DW), .GATE_LONG(GL), .CYC_LONG(CL),
      .GATE_SHORT(GS), .CYC_SHORT(CS), .PUMP_CLKS(PC)
   ) uut (
      .clk_ref(clk), .rst_n(rst_n), .fin_pre(fin), .target_word(target_word),
      .mode_short(mode_short), .tune_window(tune_window), .afc_en(afc_en),
      .pump_up(pump_up), .pump_dn(pump_dn), .pump_mag(pump_mag), .in_window(in_window)
   );

   always #5 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // tuner stimulus: toggles every fin_half clocks, held low when 0
   always @(negedge clk) begin
      if (fin_half == 0) begin
         fin <= 1'b0; ph <= 0;
      end else if (ph >= fin_half - 1) begin
         fin <= ~fin; ph <= 0;
      end else begin
         ph <= ph + 1;
      end
   end

   // behavioural reference
   int m_tb = 0, m_short = 0, m_tgt = 0, m_cnt = 0, m_left = 0, m_up = 0, m_mag = 0, m_win = 0;
   bit f1 = 0, f2 = 0, f3 = 0;

   always @(posedge clk) begin
      int len, gate, n_tb, e, a;
      bit edg;
      clk_no++;
      if (!rst_n) begin
         m_tb = 0; m_short = 0; m_tgt = 0; m_cnt = 0; m_left = 0;
         m_up = 0; m_mag = 0; m_win = 0; f1 = 0; f2 = 0; f3 = 0;
      end else begin
         len  = (m_short != 0) ? CS : CL;
         gate = (m_short != 0) ? GS : GL;
         edg  = f2 && !f3;
         n_tb = (m_tb == len - 1) ? 0 : m_tb + 1;
         if (m_tb == gate + 1) begin
            e = m_tgt - m_cnt;
            a = (e < 0) ? -e : e;
            m_win  = (a <= int'(tune_window)) ? 1 : 0;
            m_mag  = (a > MMAX) ? MMAX : a;
            m_up   = (e > 0) ? 1 : 0;
            m_left = (a != 0 && (m_win == 0 || afc_en)) ? PC : 0;
         end else if (m_left > 0) begin
            m_left--;
         end
         if (m_tb == 0) m_cnt = 0;
         else if (m_tb <= gate && edg && m_cnt < CMAX) m_cnt++;
         if (m_tb == 0) begin
            m_short = int'(mode_short);
            m_tgt   = int'(target_word);
         end
         m_tb = n_tb;
         f3 = f2; f2 = f1; f1 = fin;
      end
   end

   always @(negedge clk) begin
      if (run_cmp && !done) begin
         chk("R4 up",   int'(pump_up),   (m_left > 0 && m_up != 0) ? 1 : 0);
         chk("R4 dn",   int'(pump_dn),   (m_left > 0 && m_up == 0) ? 1 : 0);
         chk("R5 mag",  int'(pump_mag),  m_mag);
         chk("R7 win",  int'(in_window), m_win);
      end
   end

   task automatic wait_result();
      do @(negedge clk); while (m_tb != (((m_short != 0) ? GS : GL) + 2));
   endtask

   task automatic wait_rise(output longint t);
      logic prev;
      prev = pump_up;
      forever begin
         @(negedge clk);
         if (pump_up && !prev) break;
         prev = pump_up;
      end
      t = clk_no;
   endtask

   initial begin
      longint t0, t1, t2, t3;
      int n;
      target_word = 6'd5; tune_window = '0; mode_short = 1'b0; afc_en = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 up", int'(pump_up), 0);
      chk("R1 dn", int'(pump_dn), 0);
      chk("R1 mag", int'(pump_mag), 0);
      chk("R1 win", int'(in_window), 0);
      rst_n = 1'b1;
      run_cmp = 1;
      @(negedge clk);
      chk("R1 idle", int'(pump_up | pump_dn), 0);

      // fin idle, target 5: count 0, error +5
      wait_result();
      chk("R4 up", int'(pump_up), 1);
      chk("R4 dn", int'(pump_dn), 0);
      chk("R5 mag", int'(pump_mag), 5);
      chk("R7 win", int'(in_window), 0);
      n = 0;
      while (pump_up) begin n++; @(negedge clk); end
      chk("R6 width", n, PC);

      // cycle lengths and mode change
      wait_rise(t0);
      wait_rise(t1);
      chk("R2 long", int'(t1 - t0), CL);
      mode_short = 1'b1;
      wait_rise(t2);
      chk("R9 mode", int'(t2 - t1), CL + GS - GL);
      wait_rise(t3);
      chk("R2 short", int'(t3 - t2), CS);

      // target change inside the gate
      do @(negedge clk); while (m_tb != 20);
      target_word = 6'd3;
      wait_result();
      chk("R9 old target", int'(pump_mag), 5);
      wait_result();
      chk("R9 new target", int'(pump_mag), 3);

      // inside window, AFC off then on
      target_word = 6'd2; tune_window = 3'd3;
      wait_result(); wait_result();
      chk("R7 inwin", int'(in_window), 1);
      chk("R8 no pump", int'(pump_up | pump_dn), 0);
      chk("R5 mag", int'(pump_mag), 2);
      afc_en = 1'b1;
      wait_result(); wait_result();
      chk("R8 afc pump", int'(pump_up), 1);
      chk("R8 afc mag", int'(pump_mag), 2);

      // burst after gate must not reach next count
      afc_en = 1'b0; tune_window = '0; target_word = 6'd5;
      wait_result();
      do @(negedge clk); while (m_tb != GS + 5);
      fin_half = 1;
      repeat (20) @(negedge clk);
      fin_half = 0;
      wait_result();
      chk("R3 ignored", int'(pump_mag), 5);
      chk("R3 up", int'(pump_up), 1);

      // saturation: ~100 edges in long gate, 6-bit count
      mode_short = 1'b0; target_word = 6'd10; fin_half = 1;
      wait_result(); wait_result();
      chk("R10 dn", int'(pump_dn), 1);
      chk("R10 mag", int'(pump_mag), MMAX);
      chk("R4 not up", int'(pump_up), 0);
      chk("R7 out", int'(in_window), 0);

      // moderate input: ~50 edges against target 50
      target_word = 6'd50; tune_window = 3'd2; fin_half = 2;
      wait_result(); wait_result();
      chk("R7 near", int'(in_window), 1);
      chk("R8 quiet", int'(pump_up | pump_dn), 0);

      repeat (5) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL R2 watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule